// File: doc/BRIEF.md
# Receive Sampling Delay Calibration Engine

This engine searches for a working receive sampling delay without software stepping through it. After a start request it walks a 7-bit delay code through every value from the lower bound to the upper bound in steps of one. Each time the code changes it sends a resynchronisation pulse to the delay lines and waits a fixed settling time. It then asks an external read agent, through a valid/ready request channel, for a word whose contents are known. The word that comes back on a valid/ready response channel is compared with the expected pattern, and the step counts as a pass only when the two match exactly.

While it sweeps, the engine keeps two records: the passing run it is in now, and the longest passing run seen so far. Both are kept as a start code and a length. When the sweep ends it writes the centre of the longest run to the delay output, sends one last resynchronisation pulse, and reports done. If no code passed, it raises fail and puts back the delay code that was in place before the sweep began. The read agent does the actual flash access and is outside this block.

Back-pressure: the engine raises `rd_req_valid` and holds it, with `dly_code` unchanged, until it samples `rd_req_ready` high. It raises `rd_rsp_ready` only while it is waiting for the word of the current step. A response beat counts only on a clock edge where both `rd_rsp_valid` and `rd_rsp_ready` are high. Each request carries exactly one response.

Top module: `rxdly_cal_engine`

## Requirements
- R1: After reset `dly_code` and `cal_dly` are 0, `resync` is high, and `rd_req_valid`, `rd_rsp_ready`, `done` and `fail` are low.
- R2: A start accepted while idle or done sweeps `dly_code` from 0 up to 127, one step at a time. Exactly one test read is accepted per code, in ascending order, and the sweep ends after the read at code 127.
- R3: Every change of `dly_code` happens in a cycle where `resync` is low. `resync` is low for exactly one cycle and then returns high, so each sweep produces 129 low pulses: 128 steps plus one final pulse.
- R4: `rd_req_valid` rises exactly 20 cycles after `resync` returns high.
- R5: Once `rd_req_valid` is high, it and `dly_code` stay unchanged until the engine samples `rd_req_ready` high. A response beat counts only while `rd_rsp_ready` is high, and `rd_rsp_valid` at any other time has no effect on the result.
- R6: A step passes only if the 16-bit `rd_rsp_data` equals `expect_pattern` in every bit. A single differing bit makes the step fail.
- R7: The engine selects the longest run of consecutive passing codes. When two runs have the same length, the one that starts at the lower code is selected.
- R8: On success, `dly_code` and `cal_dly` both become start + floor(length/2) of the selected run, `fail` is low, and `done` rises in the cycle after the final `resync` low pulse.
- R9: If no code passes, `fail` is raised with `done`, `dly_code` goes back to the value it held just before the start, and `cal_dly` keeps its previous value.
- R10: A start during a sweep is ignored. `done`, `fail` and `dly_code` hold until the next start, and an accepted start clears `done` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a sweep when the engine is idle or done |
| expect_pattern | input | 16 | Word the test read should return |
| rd_req_valid | output | 1 | Test read request |
| rd_req_ready | input | 1 | Read agent accepts the request |
| rd_rsp_valid | input | 1 | Read data beat is present |
| rd_rsp_ready | output | 1 | Engine is waiting for the read word |
| rd_rsp_data | input | 16 | Returned read word |
| dly_code | output | 7 | Receive delay code currently applied |
| resync | output | 1 | Idles high; a one-cycle low pulse triggers delay-line resynchronisation |
| cal_dly | output | 7 | Centre code from the last successful sweep |
| done | output | 1 | Sweep finished; held until the next start |
| fail | output | 1 | No passing code found; held until the next start |

## Verification
The bench runs full 128-code sweeps against pass maps that cover these cases:
- every code passing,
- no code passing,
- a single pass at the top code,
- a single pass at code 0 among alternating codes,
- two equal runs, including one at each end of the range,
- unequal runs.

For each map it works out the expected centre itself, so a tracker that let a later run win a tie, or that measured the length wrong, ends on the wrong code. Stray response beats carrying the passing pattern arrive while no read is outstanding; an engine that accepted them would count failing codes as passing. A start is pulsed in the middle of a sweep; an engine that restarted would repeat codes and break the ascending-order check. Each fail run must bring back the pre-sweep code, so a design that left the last swept code or the reset value in place is caught.

// File: rtl/rxcal_pkg.sv
`timescale 1ns/1ps
package rxcal_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RESYNC,
    S_SETTLE,
    S_REQ,
    S_RSP,
    S_FINAL,
    S_FRESYNC,
    S_DONE
  } cal_state_e;
endpackage

// File: rtl/rxcal_settle_timer.sv
`timescale 1ns/1ps
// Counts the settling wait that follows each resync pulse.
module rxcal_settle_timer #(
  parameter int SETTLE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic expired
);
  localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(SETTLE_CYC - 1);
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/rxcal_run_tracker.sv
`timescale 1ns/1ps
// Follows the current passing run and the longest run seen so far.
module rxcal_run_tracker #(
  parameter int DLY_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             pass,
  input  logic [DLY_W-1:0] code,
  output logic             found,
  output logic [DLY_W-1:0] best_mid
);
  localparam int LEN_W = DLY_W + 1;

  logic [DLY_W-1:0] cur_start_q, best_start_q, run_start;
  logic [LEN_W-1:0] cur_len_q, best_len_q, run_len;

  always_comb begin
    run_start = (cur_len_q == '0) ? code : cur_start_q;
    run_len   = cur_len_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else if (step) begin
      if (pass) begin
        cur_start_q <= run_start;
        cur_len_q   <= run_len;
        // strict compare: an equal later run never displaces the earlier one
        if (run_len > best_len_q) begin
          best_start_q <= run_start;
          best_len_q   <= run_len;
        end
      end else begin
        cur_len_q <= '0;
      end
    end
  end

  assign found    = (best_len_q != '0);
  assign best_mid = best_start_q + DLY_W'(best_len_q >> 1);
endmodule

// File: rtl/rxdly_cal_engine.sv
`timescale 1ns/1ps
module rxdly_cal_engine #(
  parameter int DLY_W      = 7,
  parameter int DATA_W     = 16,
  parameter int DLY_MIN    = 0,
  parameter int DLY_MAX    = (1 << DLY_W) - 1,
  parameter int SETTLE_CYC = 20,
  parameter int DLY_RST    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] expect_pattern,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic [DLY_W-1:0]  dly_code,
  output logic              resync,
  output logic [DLY_W-1:0]  cal_dly,
  output logic              done,
  output logic              fail
);
  import rxcal_pkg::*;

  localparam logic [DLY_W-1:0] CODE_LO  = DLY_W'(DLY_MIN);
  localparam logic [DLY_W-1:0] CODE_HI  = DLY_W'(DLY_MAX);
  localparam logic [DLY_W-1:0] CODE_RST = DLY_W'(DLY_RST);

  cal_state_e       state_q;
  logic [DLY_W-1:0] dly_q, saved_q, cal_q;
  logic             fail_q;

  logic             start_ok, rsp_fire, step_pass, settle_done, run_found;
  logic [DLY_W-1:0] run_mid;

  assign start_ok  = start && ((state_q == S_IDLE) || (state_q == S_DONE));
  assign rsp_fire  = (state_q == S_RSP) && rd_rsp_valid;
  assign step_pass = (rd_rsp_data == expect_pattern);

  rxcal_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (state_q == S_RESYNC),
    .tick    (state_q == S_SETTLE),
    .expired (settle_done)
  );

  rxcal_run_tracker #(.DLY_W(DLY_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_ok),
    .step     (rsp_fire),
    .pass     (step_pass),
    .code     (dly_q),
    .found    (run_found),
    .best_mid (run_mid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      dly_q   <= CODE_RST;
      saved_q <= CODE_RST;
      cal_q   <= CODE_RST;
      fail_q  <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE, S_DONE: begin
          if (start) begin
            saved_q <= dly_q;
            dly_q   <= CODE_LO;
            fail_q  <= 1'b0;
            state_q <= S_RESYNC;
          end
        end
        S_RESYNC: state_q <= S_SETTLE;
        S_SETTLE: if (settle_done) state_q <= S_REQ;
        S_REQ:    if (rd_req_ready) state_q <= S_RSP;
        S_RSP: begin
          if (rd_rsp_valid) begin
            if (dly_q == CODE_HI) begin
              state_q <= S_FINAL;
            end else begin
              dly_q   <= dly_q + 1'b1;
              state_q <= S_RESYNC;
            end
          end
        end
        S_FINAL: begin
          if (run_found) begin
            dly_q <= run_mid;
            cal_q <= run_mid;
          end else begin
            dly_q  <= saved_q;
            fail_q <= 1'b1;
          end
          state_q <= S_FRESYNC;
        end
        S_FRESYNC: state_q <= S_DONE;
        default:   state_q <= S_IDLE;
      endcase
    end
  end

  assign resync       = !((state_q == S_RESYNC) || (state_q == S_FRESYNC));
  assign rd_req_valid = (state_q == S_REQ);
  assign rd_rsp_ready = (state_q == S_RSP);
  assign done         = (state_q == S_DONE);
  assign fail         = fail_q && (state_q == S_DONE);
  assign dly_code     = dly_q;
  assign cal_dly      = cal_q;
endmodule

// File: rtl/rxdly_cal_engine_chk.sv
`timescale 1ns/1ps
module rxdly_cal_engine_chk #(
  parameter int DLY_W      = 7,
  parameter int SETTLE_CYC = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_req_valid,
  input logic             rd_req_ready,
  input logic             rd_rsp_ready,
  input logic [DLY_W-1:0] dly_code,
  input logic             resync,
  input logic             done,
  input logic             fail
);
  logic [15:0] since_hi;

  always_ff @(posedge clk) begin
    if (!rst_n || !resync) since_hi <= '0;
    else if (since_hi != 16'hFFFF) since_hi <= since_hi + 1'b1;
  end

  p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !resync |=> resync);

  p_code_with_resync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dly_code) |-> !resync);

  p_settle_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_valid) |-> (since_hi >= 16'(SETTLE_CYC)));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(dly_code)));

  p_one_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && rd_rsp_ready));

  p_done_after_resync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !$past(resync));

  p_fail_only_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

  p_quiet_when_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rd_req_valid && !rd_rsp_ready && resync));
endmodule

bind rxdly_cal_engine rxdly_cal_engine_chk #(
  .DLY_W      (DLY_W),
  .SETTLE_CYC (SETTLE_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_rsp_ready (rd_rsp_ready),
  .dly_code     (dly_code),
  .resync       (resync),
  .done         (done),
  .fail         (fail)
);

// File: tb/rxdly_cal_engine_test.sv
`timescale 1ns/1ps
module rxdly_cal_engine_test;
  localparam int DW     = 16;
  localparam int NCODE  = 128;
  localparam int SETTLE = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [DW-1:0] expect_pattern;
  logic          rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready;
  logic [DW-1:0] rd_rsp_data;
  logic [6:0]    dly_code, cal_dly;
  logic          resync, done, fail;

  always #2.5 clk = ~clk;

  rxdly_cal_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .expect_pattern(expect_pattern),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data), .dly_code(dly_code), .resync(resync),
    .cal_dly(cal_dly), .done(done), .fail(fail)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [NCODE-1:0] pmap;
  logic [DW-1:0]    flip;
  bit  stray_en;
  int  exp_idx, since, low_w, rs_lows;
  bit  prev_valid;
  logic [6:0] prev_code;
  int  exp_cal, prev_dly;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor, then stub read agent, once per falling edge
  initial begin
    int ph, wcnt;
    logic [6:0] lat_code;
    ph = 0; wcnt = 0; lat_code = '0;
    rd_req_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    prev_valid = 1'b0; prev_code = '0; since = 0; low_w = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_valid && !rd_req_ready)
          chk(rd_req_valid && (dly_code == prev_code), "R5 request held",
              int'(dly_code), int'(prev_code));
        if (!resync) low_w++;
        else if (low_w != 0) begin
          chk(low_w == 1, "R3 resync low width", low_w, 1);
          rs_lows++;
          low_w = 0;
          since = 0;
        end
        if (rd_req_valid && !prev_valid) begin
          chk(since == SETTLE, "R4 settle before read", since, SETTLE);
          chk(int'(dly_code) == exp_idx, "R2 sweep order", int'(dly_code), exp_idx);
          exp_idx++;
        end
        if (resync) since++;
      end
      prev_valid = rd_req_valid;
      prev_code  = dly_code;
      case (ph)
        0: begin
          rd_rsp_valid = stray_en && !resync;
          rd_rsp_data  = expect_pattern;
          if (rd_req_valid && !rd_req_ready) begin
            if (wcnt >= int'(dly_code) % 3) begin
              rd_req_ready = 1'b1; lat_code = dly_code; ph = 1; wcnt = 0;
            end else wcnt++;
          end
        end
        1: begin
          rd_req_ready = 1'b0;
          rd_rsp_valid = 1'b0;
          wcnt++;
          if (wcnt >= 1 + int'(lat_code) % 2) begin
            rd_rsp_valid = 1'b1;
            rd_rsp_data  = pmap[lat_code] ? expect_pattern : (expect_pattern ^ flip);
            ph = 2; wcnt = 0;
          end
        end
        default: begin
          rd_rsp_valid = 1'b0;
          ph = 0;
        end
      endcase
    end
  end

  function automatic logic [NCODE-1:0] span(input int lo, input int hi);
    logic [NCODE-1:0] m = '0;
    for (int i = lo; i <= hi; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic run_cal(input logic [NCODE-1:0] m, input logic [DW-1:0] pat,
                         input logic [DW-1:0] f, input bit mid_start, input string name);
    int bs, bl, cs, cl, exp_mid;
    pmap = m; flip = f; expect_pattern = pat;
    exp_idx = 0; rs_lows = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!done, "R10 start clears done", int'(done), 0);
    if (mid_start) begin
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    bs = 0; bl = 0; cs = 0; cl = 0;
    for (int c = 0; c < NCODE; c++) begin
      if (m[c]) begin
        if (cl == 0) cs = c;
        cl++;
        if (cl > bl) begin bs = cs; bl = cl; end
      end else cl = 0;
    end
    $display("run %s", name);
    chk(exp_idx == NCODE, "R2 reads per sweep", exp_idx, NCODE);
    chk(rs_lows == NCODE + 1, "R3 resync pulses per sweep", rs_lows, NCODE + 1);
    if (bl > 0) begin
      exp_mid = bs + bl / 2;
      chk(int'(dly_code) == exp_mid, "R7 R8 R6 R5 centre code", int'(dly_code), exp_mid);
      chk(int'(cal_dly) == exp_mid, "R8 cal_dly", int'(cal_dly), exp_mid);
      chk(!fail, "R8 no fail", int'(fail), 0);
      exp_cal = exp_mid; prev_dly = exp_mid;
    end else begin
      chk(fail, "R9 fail raised", int'(fail), 1);
      chk(int'(dly_code) == prev_dly, "R9 code restored", int'(dly_code), prev_dly);
      chk(int'(cal_dly) == exp_cal, "R9 cal_dly kept", int'(cal_dly), exp_cal);
    end
    repeat (40) @(negedge clk);
    chk(done, "R10 done held", int'(done), 1);
    chk(int'(dly_code) == prev_dly, "R10 code held", int'(dly_code), prev_dly);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [NCODE-1:0] alt;
    rst_n = 1'b0; start = 1'b0; stray_en = 1'b0;
    expect_pattern = '0; pmap = '0; flip = 16'h1;
    exp_cal = 0; prev_dly = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dly_code == 7'd0, "R1 dly_code", int'(dly_code), 0);
    chk(cal_dly == 7'd0, "R1 cal_dly", int'(cal_dly), 0);
    chk(resync, "R1 resync idle high", int'(resync), 1);
    chk(!rd_req_valid && !rd_rsp_ready, "R1 no traffic",
        int'(rd_req_valid) + int'(rd_rsp_ready), 0);
    chk(!done && !fail, "R1 done and fail low", int'(done) + int'(fail), 0);

    stray_en = 1'b1;
    alt = '0;
    for (int i = 0; i < NCODE; i += 2) alt[i] = 1'b1;
    run_cal('1, 16'hA5C3, 16'h0001, 1'b1, "all pass");
    run_cal('0, 16'h3C5A, 16'h8000, 1'b0, "none pass");
    run_cal(span(127, 127), 16'hFFFF, 16'h0100, 1'b0, "top only");
    run_cal(span(10, 19) | span(50, 59), 16'h1234, 16'h0010, 1'b0, "tie");
    run_cal(span(5, 8) | span(100, 106), 16'h0000, 16'h4000, 1'b0, "longer later");
    run_cal(alt, 16'h5555, 16'h0002, 1'b0, "alternating");
    run_cal(span(0, 2) | span(125, 127), 16'hBEEF, 16'h0800, 1'b0, "tie at edges");
    run_cal('0, 16'hC001, 16'h0020, 1'b0, "none pass again");
    run_cal(span(3, 126), 16'h7E81, 16'h0004, 1'b0, "wide");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule